// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel RGB or YUV display panel: a horizontal sync pulse, a vertical sync pulse, a data-enable strobe and a field flag. It also gives the position of the current pixel and line inside the visible area, so that a downstream pixel-fetch stage knows which frame-buffer word to present. All timing advances only on cycles where the pixel-clock enable is high.

Software programs the sync widths, the porches and the visible size through a small write port. Two 32-bit timing words carry the vertical and horizontal fields. A control word holds the interlace enable and one polarity-inversion bit for each timing output. Timing values are copied into shadow registers at the first pixel of each vertical sync, so one frame never mixes old and new settings. In interlaced mode the field flag alternates frame by frame, and the even field uses its own vertical back and front porch.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is applied and right after it is released, the block sits at the first pixel of the first line. It shows hsync=1, vsync=1, de=0, field=0, pix_x=0 and line_y=0, and every register and shadow value is zero.
- R2: One line is made of four phases, in this order: sync for HSW+1 enabled pixel clocks (hsync asserted), back porch for HBP+1, active for AW+1 and front porch for HFP+1. A programmed value N always yields N+1 units.
- R3: One frame is made of these lines, in this order: sync for VSW+1 lines (vsync asserted), back porch for VBP+1, active for AH+1 and front porch for VFP+1. The line count advances at the first pixel clock of hsync.
- R4: de is asserted only when both the horizontal and the vertical position are inside their active phase. pix_x counts 0..AW across the horizontal active phase and is 0 elsewhere. line_y counts 0..AH across the vertical active lines and is 0 elsewhere.
- R5: While pix_en is low, no counter, position output or field value changes.
- R6: The write port decodes wr_addr as follows. Address 0 is the vertical word: VSW [7:0], VFP [15:8], VBP [23:16], even-field VBP [31:24]. Address 1 is the horizontal word: HSW [7:0], HFP [15:8], HBP [23:16], even-field VFP [31:24]. Address 2 is the control word. Address 3 is AW in [10:0] and address 4 is AH in [10:0]. Other addresses are ignored.
- R7: Timing values written during a frame take effect only from the next frame start (first pixel of vertical sync). The frame in progress completes with the old values.
- R8: Control bits 6, 5 and 4 invert hsync, vsync and de respectively (0 = normal, 1 = inverted). They act from the cycle after the write, with no wait for the frame start.
- R9: Control bit 0 enables interlace. When it is set, field toggles at each frame start, and a frame with field=1 uses the even-field VBP and VFP. When it is clear, field becomes 0 at the next frame start and the even-field values are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable; timing advances only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per control bit 6 |
| vsync | output | 1 | Vertical sync, polarity per control bit 5 |
| de | output | 1 | Data enable, polarity per control bit 4 |
| field | output | 1 | 1 while the even field of an interlaced frame is shown |
| pix_x | output | AW | Pixel index inside the active line |
| line_y | output | AW | Line index inside the active area |

## Verification
The bench uses the default parameters: 8-bit porch and sync fields and 11-bit active size. It programs small values, so a frame lasts only a few hundred cycles. This lets several complete frames be compared cycle by cycle against an independent model of the phase sequence. Because the frames are short, the bench can reach the frame-boundary events within its run: shadow loading after a mid-frame write, field alternation with even-field porches, a pixel-enable stall inside a line, and polarity changes that act at once.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int PW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          field,
  output logic [AW-1:0] pix_x,
  output logic [AW-1:0] line_y
);
  localparam int CW = ((AW > PW) ? AW : PW) + 2;
  localparam int L0 = 0;
  localparam int L1 = 8;
  localparam int L2 = 16;
  localparam int L3 = 24;

  logic [31:0]   reg_v, reg_h;
  logic [AW-1:0] reg_aw, reg_ah;
  logic          inv_h, inv_v, inv_d, ilace;

  logic [PW-1:0] s_vsw, s_vfp, s_vbp, s_vbpe, s_vfpe;
  logic [PW-1:0] s_hsw, s_hfp, s_hbp;
  logic [AW-1:0] s_aw, s_ah;

  logic [CW-1:0] hcnt, vcnt;
  logic [CW-1:0] h_bp_start, h_act_start, h_fp_start, h_total;
  logic [CW-1:0] v_bp_start, v_act_start, v_fp_start, v_total;
  logic [PW-1:0] vbp_sel, vfp_sel;
  logic          h_last, v_last, frame_end;
  logic          h_in, v_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_v  <= '0;
      reg_h  <= '0;
      reg_aw <= '0;
      reg_ah <= '0;
      inv_h  <= 1'b0;
      inv_v  <= 1'b0;
      inv_d  <= 1'b0;
      ilace  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: reg_v <= wr_data;
        3'd1: reg_h <= wr_data;
        3'd2: begin
          inv_h <= wr_data[6];
          inv_v <= wr_data[5];
          inv_d <= wr_data[4];
          ilace <= wr_data[0];
        end
        3'd3: reg_aw <= wr_data[AW-1:0];
        3'd4: reg_ah <= wr_data[AW-1:0];
        default: ;
      endcase
    end
  end

  assign vbp_sel = field ? s_vbpe : s_vbp;
  assign vfp_sel = field ? s_vfpe : s_vfp;

  assign h_bp_start  = CW'(s_hsw) + CW'(1);
  assign h_act_start = h_bp_start + CW'(s_hbp) + CW'(1);
  assign h_fp_start  = h_act_start + CW'(s_aw) + CW'(1);
  assign h_total     = h_fp_start + CW'(s_hfp) + CW'(1);

  assign v_bp_start  = CW'(s_vsw) + CW'(1);
  assign v_act_start = v_bp_start + CW'(vbp_sel) + CW'(1);
  assign v_fp_start  = v_act_start + CW'(s_ah) + CW'(1);
  assign v_total     = v_fp_start + CW'(vfp_sel) + CW'(1);

  assign h_last    = (hcnt == h_total - CW'(1));
  assign v_last    = (vcnt == v_total - CW'(1));
  assign frame_end = pix_en && h_last && v_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pix_en) begin
      hcnt <= h_last ? '0 : hcnt + CW'(1);
      if (h_last)
        vcnt <= v_last ? '0 : vcnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_vsw  <= '0;
      s_vfp  <= '0;
      s_vbp  <= '0;
      s_vbpe <= '0;
      s_vfpe <= '0;
      s_hsw  <= '0;
      s_hfp  <= '0;
      s_hbp  <= '0;
      s_aw   <= '0;
      s_ah   <= '0;
      field  <= 1'b0;
    end else if (frame_end) begin
      s_vsw  <= reg_v[L0 +: PW];
      s_vfp  <= reg_v[L1 +: PW];
      s_vbp  <= reg_v[L2 +: PW];
      s_vbpe <= reg_v[L3 +: PW];
      s_hsw  <= reg_h[L0 +: PW];
      s_hfp  <= reg_h[L1 +: PW];
      s_hbp  <= reg_h[L2 +: PW];
      s_vfpe <= reg_h[L3 +: PW];
      s_aw   <= reg_aw;
      s_ah   <= reg_ah;
      field  <= ilace ? ~field : 1'b0;
    end
  end

  assign h_in = (hcnt >= h_act_start) && (hcnt < h_fp_start);
  assign v_in = (vcnt >= v_act_start) && (vcnt < v_fp_start);

  assign hsync  = (hcnt < h_bp_start) ^ inv_h;
  assign vsync  = (vcnt < v_bp_start) ^ inv_v;
  assign de     = (h_in && v_in) ^ inv_d;
  assign pix_x  = h_in ? AW'(hcnt - h_act_start) : '0;
  assign line_y = v_in ? AW'(vcnt - v_act_start) : '0;

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int PW = 8,
  parameter int AW = 11,
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic [CW-1:0] hcnt,
  input logic [CW-1:0] vcnt,
  input logic [CW-1:0] h_total,
  input logic [CW-1:0] v_total,
  input logic          field,
  input logic [AW-1:0] pix_x,
  input logic [PW-1:0] s_hsw,
  input logic [AW-1:0] s_aw
);
  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) hcnt < h_total); // R2
  AST_VCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) vcnt < v_total); // R3
  AST_LINE_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n) !$stable(vcnt) |-> hcnt == '0); // R3
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && pix_x != '0) |=> (pix_x == '0 || pix_x == $past(pix_x) + AW'(1))); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hcnt) && $stable(vcnt) && $stable(field))); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(hcnt == '0 && vcnt == '0) |-> ($stable(s_hsw) && $stable(s_aw))); // R7
  AST_FIELD_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> (hcnt == '0 && vcnt == '0)); // R9
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.PW(PW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hcnt(hcnt), .vcnt(vcnt),
  .h_total(h_total), .v_total(v_total), .field(field), .pix_x(pix_x),
  .s_hsw(s_hsw), .s_aw(s_aw)
);

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
  logic clk = 1'b0;
  logic rst_n, pix_en, wr_en;
  logic [2:0] wr_addr;
  logic [31:0] wr_data;
  logic hsync, vsync, de, field;
  logic [10:0] pix_x, line_y;

  always #4 clk = ~clk;

  lcd_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de), .field(field),
    .pix_x(pix_x), .line_y(line_y)
  );

  int vectors = 0;
  int fails = 0;
  bit done_flag = 0;

  int n_vsw, n_vfp, n_vbp, n_vbpe, n_vfpe, n_hsw, n_hfp, n_hbp, n_aw, n_ah;
  bit n_ih, n_iv, n_id, n_il;
  int c_vsw, c_vfp, c_vbp, c_vbpe, c_vfpe, c_hsw, c_hfp, c_hbp, c_aw, c_ah;
  bit exp_field;
  int bh, bv;

  task automatic model_wr(input int a, input logic [31:0] d);
    case (a)
      0: begin n_vsw = d[7:0]; n_vfp = d[15:8]; n_vbp = d[23:16]; n_vbpe = d[31:24]; end
      1: begin n_hsw = d[7:0]; n_hfp = d[15:8]; n_hbp = d[23:16]; n_vfpe = d[31:24]; end
      2: begin n_ih = d[6]; n_iv = d[5]; n_id = d[4]; n_il = d[0]; end
      3: n_aw = d[10:0];
      4: n_ah = d[10:0];
      default: ;
    endcase
  endtask

  task automatic load_cur();
    c_vsw = n_vsw; c_vfp = n_vfp; c_vbp = n_vbp; c_vbpe = n_vbpe; c_vfpe = n_vfpe;
    c_hsw = n_hsw; c_hfp = n_hfp; c_hbp = n_hbp; c_aw = n_aw; c_ah = n_ah;
  endtask

  task automatic check_bit(input string tag, input string sig, input logic got, input logic exp);
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s h=%0d v=%0d got %b expected %b", tag, sig, bh, bv, got, exp);
    end
  endtask

  task automatic check_num(input string tag, input string sig, input int got, input int exp);
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s h=%0d v=%0d got %0d expected %0d", tag, sig, bh, bv, got, exp);
    end
  endtask

  function automatic int h_tot();
    return c_hsw + c_hbp + c_aw + c_hfp + 4;
  endfunction

  function automatic int v_tot();
    int vb, vf;
    vb = exp_field ? c_vbpe : c_vbp;
    vf = exp_field ? c_vfpe : c_vfp;
    return c_vsw + vb + c_ah + vf + 4;
  endfunction

  task automatic check_pos(input string tag);
    int ha, va, vb;
    bit hin, vin;
    vb = exp_field ? c_vbpe : c_vbp;
    ha = c_hsw + c_hbp + 2;
    va = c_vsw + vb + 2;
    hin = (bh >= ha) && (bh <= ha + c_aw);
    vin = (bv >= va) && (bv <= va + c_ah);
    vectors++;
    check_bit({tag, "/R2"}, "hsync", hsync, (bh <= c_hsw) ^ n_ih);
    check_bit({tag, "/R3"}, "vsync", vsync, (bv <= c_vsw) ^ n_iv);
    check_bit({tag, "/R4"}, "de", de, (hin && vin) ^ n_id);
    check_num({tag, "/R4"}, "pix_x", int'(pix_x), hin ? bh - ha : 0);
    check_num({tag, "/R4"}, "line_y", int'(line_y), vin ? bv - va : 0);
    check_bit({tag, "/R9"}, "field", field, exp_field);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pix_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    n_vsw = 0; n_vfp = 0; n_vbp = 0; n_vbpe = 0; n_vfpe = 0;
    n_hsw = 0; n_hfp = 0; n_hbp = 0; n_aw = 0; n_ah = 0;
    n_ih = 0; n_iv = 0; n_id = 0; n_il = 0;
    exp_field = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    model_wr(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input string tag, input int nfr, input int stall_at,
                     input int wr_at, input int wa, input logic [31:0] wd);
    bit prev, lv;
    int frames, cyc, g;
    pix_en = 1'b1;
    prev = 1'b1;
    for (g = 0; g < 5000; g++) begin
      @(negedge clk);
      lv = vsync ^ n_iv;
      if (lv && !prev) break;
      prev = lv;
    end
    load_cur();
    exp_field = n_il ? ~exp_field : 1'b0;
    bh = 0; bv = 0; frames = 0; cyc = 0;
    while (frames < nfr) begin
      check_pos(tag);
      wr_en = 1'b0;
      if (cyc == wr_at) begin
        wr_en = 1'b1; wr_addr = 3'(wa); wr_data = wd;
        model_wr(wa, wd);
      end
      pix_en = !(stall_at >= 0 && cyc >= stall_at && cyc < stall_at + 4);
      if (pix_en) begin
        bh++;
        if (bh == h_tot()) begin
          bh = 0;
          bv++;
          if (bv == v_tot()) begin
            bv = 0;
            frames++;
            load_cur();
            exp_field = n_il ? ~exp_field : 1'b0;
          end
        end
      end
      cyc++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    pix_en = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0; pix_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    vectors++;
    if ({hsync, vsync, de, field} !== 4'b1100 || pix_x !== '0 || line_y !== '0) begin
      fails++;
      $display("FAIL R1 in reset got hs=%b vs=%b de=%b f=%b x=%0d y=%0d expected 1 1 0 0 0 0",
               hsync, vsync, de, field, pix_x, line_y);
    end
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if ({hsync, vsync, de, field} !== 4'b1100 || pix_x !== '0 || line_y !== '0) begin
      fails++;
      $display("FAIL R1 after reset got hs=%b vs=%b de=%b f=%b x=%0d y=%0d expected 1 1 0 0 0 0",
               hsync, vsync, de, field, pix_x, line_y);
    end
  endtask

  task automatic test_progressive();
    do_reset();
    cfg_wr(0, {8'd9, 8'd2, 8'd1, 8'd1});
    cfg_wr(1, {8'd7, 8'd3, 8'd1, 8'd2});
    cfg_wr(3, 32'd7);
    cfg_wr(4, 32'd3);
    cfg_wr(5, 32'hFFFF_FFFF);
    cfg_wr(2, 32'h0);
    run("R6", 2, -1, -1, 0, '0);
  endtask

  task automatic test_stall();
    do_reset();
    cfg_wr(0, {8'd0, 8'd1, 8'd0, 8'd2});
    cfg_wr(1, {8'd0, 8'd0, 8'd2, 8'd1});
    cfg_wr(3, 32'd5);
    cfg_wr(4, 32'd2);
    run("R5", 1, 40, -1, 0, '0);
  endtask

  task automatic test_shadow();
    do_reset();
    cfg_wr(0, {8'd0, 8'd1, 8'd1, 8'd1});
    cfg_wr(1, {8'd0, 8'd2, 8'd1, 8'd1});
    cfg_wr(3, 32'd4);
    cfg_wr(4, 32'd2);
    run("R7", 2, -1, 30, 1, {8'd0, 8'd1, 8'd3, 8'd5});
  endtask

  task automatic test_polarity();
    do_reset();
    cfg_wr(0, {8'd0, 8'd1, 8'd1, 8'd1});
    cfg_wr(1, {8'd0, 8'd1, 8'd1, 8'd1});
    cfg_wr(3, 32'd3);
    cfg_wr(4, 32'd2);
    cfg_wr(2, 32'h70);
    run("R8", 2, -1, 20, 2, 32'h20);
  endtask

  task automatic test_interlace();
    do_reset();
    cfg_wr(0, {8'd4, 8'd1, 8'd2, 8'd0});
    cfg_wr(1, {8'd3, 8'd1, 8'd1, 8'd1});
    cfg_wr(3, 32'd3);
    cfg_wr(4, 32'd2);
    cfg_wr(2, 32'h01);
    run("R9", 3, -1, -1, 0, '0);
  endtask

  initial begin
    test_reset();
    test_progressive();
    test_stall();
    test_shadow();
    test_polarity();
    test_interlace();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule